// File: doc/BRIEF.md
# Scalar Integer Extension ALU

This unit executes a compact group of general-register integer operations in one pass: absolute value, population count, trailing-zero count, and the four minimum/maximum variants (signed and unsigned). The caller presents an opcode, two register operands, an 8-bit immediate, an immediate-select bit and a size bit, together with `in_valid`. One clock later the registered result appears with `out_valid`.

The min/max operations can take the 8-bit immediate in place of the second register. Signed forms sign-extend it and unsigned forms zero-extend it. The size bit chooses 64-bit or 32-bit operation. In 32-bit mode only the low half of each operand is examined and the upper half of the result is zero. No operation ever requests a condition-flag update, so the unit can sit beside a flag-setting ALU without any flag merge logic.

Top module: `gpr_ext_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `result` is loaded only on those cycles and holds its value while `in_valid` is low.
- R2: After reset, `out_valid` is 0 and `result` is 0.
- R3: Opcode encoding: 0 abs, 1 popcount, 2 trailing-zero count, 3 signed max, 4 signed min, 5 unsigned max, 6 unsigned min. Code 7 is reserved and yields a result of 0.
- R4: Abs returns the two's-complement negation of the operand when its sign bit (bit 63, or bit 31 in 32-bit mode) is set, and the operand unchanged otherwise. The most negative value wraps to itself.
- R5: Popcount returns the number of set bits in the examined width.
- R6: Trailing-zero count returns the number of zero bits below the lowest set bit, which equals the leading-zero count of the bit-reversed operand. An all-zero operand returns the width (32 or 64).
- R7: Signed max/min with a register operand return the larger/smaller of the two operands read as two's-complement numbers.
- R8: Unsigned max/min with a register operand return the larger/smaller of the two operands read as unsigned numbers.
- R9: When `use_imm` is 1, min/max use `imm8` as the second operand, sign-extended for opcodes 3/4 and zero-extended for 5/6. `src_b` then has no effect on the result.
- R10: With `is_64` = 0, only bits 31:0 of the operands are examined and `result[63:32]` is 0. With `is_64` = 1 all 64 bits are used.
- R11: `flags_we` is 0 for every opcode and in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| op | input | 3 | Opcode (see R3) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm8 | input | 8 | 8-bit immediate for min/max |
| use_imm | input | 1 | Select immediate as second operand |
| is_64 | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered result |
| flags_we | output | 1 | Condition-flag write enable, always 0 |

## Verification
Min/max are driven with operand pairs whose sign bits differ, so that signed and unsigned forms choose opposite operands, and with equal operands. Abs is tried with positive, negative and most-negative inputs in both widths, so that a wrong sign-bit position or missing wrap shows up. Trailing-zero count is run with lowest set bits at 0, in the middle, at the top bit and with zero input, and the 32-bit cases carry junk in the upper half to expose leaks across the size boundary. Immediate forms use `imm8` values with bit 7 set, which separates sign- from zero-extension, and vary `src_b` to show that it is ignored.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int OPCODE_W = 3;

  typedef enum logic [OPCODE_W-1:0] {
    OP_ABS  = 3'd0,
    OP_CNT  = 3'd1,
    OP_CTZ  = 3'd2,
    OP_SMAX = 3'd3,
    OP_SMIN = 3'd4,
    OP_UMAX = 3'd5,
    OP_UMIN = 3'd6,
    OP_RSVD = 3'd7
  } gx_op_e;
endpackage

// File: rtl/gx_operand_prep.sv
module gx_operand_prep #(
  parameter int XLEN = 64
) (
  input  logic            is_64,
  input  logic            signed_view,
  input  logic            use_imm,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [7:0]      imm8,
  output logic [XLEN-1:0] a_view,
  output logic [XLEN:0]   a_ext,
  output logic [XLEN:0]   b_ext
);
  localparam int HALF = XLEN / 2;

  // Zero-extends the examined part of an operand to XLEN bits.
  function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic w64);
    if (w64) return v;
    return {{(XLEN-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  // Widens the examined part to XLEN+1 bits so that one signed comparator
  // serves both the signed and the unsigned forms.
  function automatic logic [XLEN:0] widen(input logic [XLEN-1:0] v, input logic w64,
                                          input logic sgn);
    logic top;
    top = sgn & (w64 ? v[XLEN-1] : v[HALF-1]);
    if (w64) return {top, v};
    return {{(XLEN-HALF+1){top}}, v[HALF-1:0]};
  endfunction

  logic [XLEN-1:0] imm_full;
  logic [XLEN-1:0] b_raw;

  assign imm_full = {{(XLEN-8){signed_view & imm8[7]}}, imm8};
  assign b_raw    = use_imm ? imm_full : src_b;
  assign a_view   = narrow(src_a, is_64);
  assign a_ext    = widen(src_a, is_64, signed_view);
  assign b_ext    = widen(b_raw, is_64, signed_view);
endmodule

// File: rtl/gx_bitcount.sv
module gx_bitcount #(
  parameter int XLEN  = 64,
  parameter int CNT_W = $clog2(XLEN + 1)
) (
  input  logic             is_64,
  input  logic [XLEN-1:0]  a_view,
  input  logic [XLEN-1:0]  src_a,
  output logic [CNT_W-1:0] pop,
  output logic [CNT_W-1:0] tz
);
  localparam int HALF = XLEN / 2;

  function automatic logic [CNT_W-1:0] pop_count(input logic [XLEN-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < XLEN; i++) n = n + {{(CNT_W-1){1'b0}}, v[i]};
    return n;
  endfunction

  function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] lead_zeros(input logic [XLEN-1:0] v);
    logic [CNT_W-1:0] n;
    logic             hit;
    n   = '0;
    hit = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  // In 32-bit mode the upper half is filled with ones so the count stops
  // at HALF when the examined half is zero.
  logic [XLEN-1:0] tz_src;
  logic [XLEN-1:0] tz_rev;

  assign tz_src = is_64 ? src_a : {{(XLEN-HALF){1'b1}}, src_a[HALF-1:0]};
  assign tz_rev = bit_reverse(tz_src);
  assign tz     = lead_zeros(tz_rev);
  assign pop    = pop_count(a_view);
endmodule

// File: rtl/gx_abs.sv
module gx_abs #(
  parameter int XLEN = 64
) (
  input  logic [XLEN:0]   a_ext,
  output logic            a_negative,
  output logic [XLEN-1:0] abs_val
);
  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN:0] v);
    logic [XLEN:0] neg;
    neg = ~v + 1'b1;
    return v[XLEN] ? neg[XLEN-1:0] : v[XLEN-1:0];
  endfunction

  assign a_negative = a_ext[XLEN];
  assign abs_val    = magnitude(a_ext);
endmodule

// File: rtl/gx_minmax.sv
module gx_minmax #(
  parameter int XLEN = 64
) (
  input  logic            want_max,
  input  logic [XLEN:0]   a_ext,
  input  logic [XLEN:0]   b_ext,
  output logic            a_below_b,
  output logic [XLEN-1:0] pick_val
);
  function automatic logic less_than(input logic [XLEN:0] x, input logic [XLEN:0] y);
    return $signed(x) < $signed(y);
  endfunction

  logic take_a;

  assign a_below_b = less_than(a_ext, b_ext);
  assign take_a    = want_max ? !a_below_b : a_below_b;
  assign pick_val  = take_a ? a_ext[XLEN-1:0] : b_ext[XLEN-1:0];
endmodule

// File: rtl/gpr_ext_alu.sv
module gpr_ext_alu
  import gx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OPCODE_W-1:0] op,
  input  logic [XLEN-1:0]     src_a,
  input  logic [XLEN-1:0]     src_b,
  input  logic [7:0]          imm8,
  input  logic                use_imm,
  input  logic                is_64,
  output logic                out_valid,
  output logic [XLEN-1:0]     result,
  output logic                flags_we
);
  localparam int HALF  = XLEN / 2;
  localparam int CNT_W = $clog2(XLEN + 1);

  gx_op_e          op_e;
  logic            signed_view;
  logic            want_max;
  logic            is_minmax;
  logic [XLEN-1:0] a_view;
  logic [XLEN:0]   a_ext;
  logic [XLEN:0]   b_ext;
  logic [CNT_W-1:0] pop;
  logic [CNT_W-1:0] tz;
  logic            a_negative;
  logic [XLEN-1:0] abs_val;
  logic            a_below_b;
  logic [XLEN-1:0] pick_val;
  logic [XLEN-1:0] raw_res;
  logic [XLEN-1:0] res_next;
  logic [XLEN-1:0] width_mask;

  assign op_e        = gx_op_e'(op);
  assign signed_view = (op_e == OP_ABS) || (op_e == OP_SMAX) || (op_e == OP_SMIN);
  assign want_max    = (op_e == OP_SMAX) || (op_e == OP_UMAX);
  assign is_minmax   = (op_e == OP_SMAX) || (op_e == OP_SMIN) ||
                       (op_e == OP_UMAX) || (op_e == OP_UMIN);

  gx_operand_prep #(.XLEN(XLEN)) u_prep (
    .is_64      (is_64),
    .signed_view(signed_view),
    .use_imm    (use_imm & is_minmax),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm8       (imm8),
    .a_view     (a_view),
    .a_ext      (a_ext),
    .b_ext      (b_ext)
  );

  gx_bitcount #(.XLEN(XLEN), .CNT_W(CNT_W)) u_bits (
    .is_64 (is_64),
    .a_view(a_view),
    .src_a (src_a),
    .pop   (pop),
    .tz    (tz)
  );

  gx_abs #(.XLEN(XLEN)) u_abs (
    .a_ext     (a_ext),
    .a_negative(a_negative),
    .abs_val   (abs_val)
  );

  gx_minmax #(.XLEN(XLEN)) u_mm (
    .want_max (want_max),
    .a_ext    (a_ext),
    .b_ext    (b_ext),
    .a_below_b(a_below_b),
    .pick_val (pick_val)
  );

  always_comb begin
    unique case (op_e)
      OP_ABS:  raw_res = abs_val;
      OP_CNT:  raw_res = {{(XLEN-CNT_W){1'b0}}, pop};
      OP_CTZ:  raw_res = {{(XLEN-CNT_W){1'b0}}, tz};
      OP_SMAX, OP_SMIN, OP_UMAX, OP_UMIN: raw_res = pick_val;
      default: raw_res = '0;
    endcase
  end

  assign width_mask = is_64 ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
  assign res_next   = raw_res & width_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_next;
    end
  end

  // This unit never requests a condition-flag update.
  assign flags_we = 1'b0;

  logic unused_ok;
  assign unused_ok = ^{a_negative, a_below_b};
endmodule

// File: rtl/gpr_ext_alu_chk.sv
module gpr_ext_alu_chk
  import gx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [OPCODE_W-1:0] op,
  input logic [XLEN-1:0]     src_a,
  input logic [XLEN-1:0]     src_b,
  input logic                use_imm,
  input logic                is_64,
  input logic                out_valid,
  input logic [XLEN-1:0]     result
);
  localparam int HALF = XLEN / 2;

  logic mm_reg64;
  assign mm_reg64 = in_valid && is_64 && !use_imm &&
                    (op == OP_SMAX || op == OP_SMIN || op == OP_UMAX || op == OP_UMIN);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));  // R1
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_RSVD) |=> (result == '0));  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CNT) |=> (result <= XLEN'(XLEN)));  // R5
  AST_CTZ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CTZ && is_64 && src_a == '0) |=> (result == XLEN'(XLEN)));  // R6
  AST_MINMAX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mm_reg64 |=> (result == $past(src_a) || result == $past(src_b)));  // R7
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_64) |=> (result[XLEN-1:HALF] == '0));  // R10
endmodule

bind gpr_ext_alu gpr_ext_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .src_a    (src_a),
  .src_b    (src_b),
  .use_imm  (use_imm),
  .is_64    (is_64),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/test_gpr_ext_alu.sv
`timescale 1ns/1ps
module test_gpr_ext_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  imm8 = '0;
  logic        use_imm = 1'b0;
  logic        is_64 = 1'b1;
  logic        out_valid;
  logic [63:0] result;
  logic        flags_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpr_ext_alu i_gpr_ext_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .imm8(imm8), .use_imm(use_imm),
    .is_64(is_64), .out_valid(out_valid), .result(result), .flags_we(flags_we)
  );

  // Independent reference written from the requirements.
  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
      input logic [63:0] b, input logic [7:0] im, input bit ui, input bit w64);
    int          n;
    logic [63:0] m, x, y, r;
    longint      sx, sy;
    bit          sgn;
    n   = w64 ? 64 : 32;
    m   = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    sgn = (o == 3'd3) || (o == 3'd4);
    x   = a & m;
    y   = ui ? (sgn ? {{56{im[7]}}, im} : {56'h0, im}) : b;
    y   = y & m;
    sx  = w64 ? $signed(x) : $signed({{32{x[31]}}, x[31:0]});
    sy  = w64 ? $signed(y) : $signed({{32{y[31]}}, y[31:0]});
    r   = '0;
    case (o)
      3'd0: r = x[n-1] ? (64'h0 - x) : x;
      3'd1: for (int i = 0; i < n; i++) r = r + 64'(x[i]);
      3'd2: begin
        int k = 0;
        while (k < n && !x[k]) k++;
        r = 64'(k);
      end
      3'd3: r = (sx >= sy) ? x : y;
      3'd4: r = (sx <= sy) ? x : y;
      3'd5: r = (x >= y) ? x : y;
      3'd6: r = (x <= y) ? x : y;
      default: r = '0;
    endcase
    return r & m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation, then sample after the registering edge.
  task automatic run(input string req, input logic [2:0] o, input logic [63:0] a,
      input logic [63:0] b, input logic [7:0] im, input bit ui, input bit w64);
    @(negedge clk);
    op = o; src_a = a; src_b = b; imm8 = im; use_imm = ui; is_64 = w64;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {63'h0, out_valid}, 64'h1);
    chk(req, result, model(o, a, b, im, ui, w64));
  endtask

  task automatic t_reset;
    chk("R2 valid", {63'h0, out_valid}, 64'h0);
    chk("R2 result", result, 64'h0);
  endtask

  task automatic t_abs;
    run("R4 pos64", 3'd0, 64'h0000_0000_0000_1234, 0, 0, 0, 1);
    run("R4 neg64", 3'd0, 64'hFFFF_FFFF_FFFF_FFF6, 0, 0, 0, 1);
    chk("R4 neg64 value", result, 64'd10);
    run("R4 min64", 3'd0, 64'h8000_0000_0000_0000, 0, 0, 0, 1);
    chk("R4 min64 wrap", result, 64'h8000_0000_0000_0000);
    run("R4 neg32", 3'd0, 64'h1234_5678_FFFF_FFFE, 0, 0, 0, 0);
    chk("R4 neg32 value", result, 64'd2);
    run("R4 min32", 3'd0, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, 0);
    chk("R4 min32 wrap", result, 64'h0000_0000_8000_0000);
    run("R4 pos32 upper junk", 3'd0, 64'h8000_0000_0000_0005, 0, 0, 0, 0);
  endtask

  task automatic t_cnt;
    run("R5 zero", 3'd1, 64'h0, 0, 0, 0, 1);
    run("R5 ones64", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1);
    chk("R5 ones64 value", result, 64'd64);
    run("R5 mixed", 3'd1, 64'hF0F0_0001_8000_0003, 0, 0, 0, 1);
    run("R5 32bit", 3'd1, 64'hFFFF_FFFF_0000_00FF, 0, 0, 0, 0);
    chk("R5 32bit value", result, 64'd8);
  endtask

  task automatic t_ctz;
    run("R6 bit0", 3'd2, 64'h1, 0, 0, 0, 1);
    run("R6 mid", 3'd2, 64'h0000_0100_0000_0000, 0, 0, 0, 1);
    chk("R6 mid value", result, 64'd40);
    run("R6 top", 3'd2, 64'h8000_0000_0000_0000, 0, 0, 0, 1);
    run("R6 zero64", 3'd2, 64'h0, 0, 0, 0, 1);
    chk("R6 zero64 width", result, 64'd64);
    run("R6 zero32", 3'd2, 64'hFFFF_0000_0000_0000, 0, 0, 0, 0);
    chk("R6 zero32 width", result, 64'd32);
    run("R6 top32", 3'd2, 64'h0000_0001_8000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_signed;
    run("R7 smax diff sign", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, 1);
    chk("R7 smax picks positive", result, 64'd5);
    run("R7 smin diff sign", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, 1);
    run("R7 smax equal", 3'd3, 64'd77, 64'd77, 0, 0, 1);
    run("R7 smin 32", 3'd4, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 0, 0, 0);
    chk("R7 smin 32 value", result, 64'h0000_0000_8000_0000);
    run("R7 smax both neg", 3'd3, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 1);
  endtask

  task automatic t_unsigned;
    run("R8 umax diff sign", 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, 1);
    chk("R8 umax picks large", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R8 umin diff sign", 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, 1);
    run("R8 umax 32 junk", 3'd5, 64'h0000_0000_0000_0010, 64'hFFFF_FFFF_0000_0001, 0, 0, 0);
    chk("R8 umax 32 value", result, 64'h10);
  endtask

  task automatic t_imm;
    run("R9 smax imm neg", 3'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'd9, 8'hFE, 1, 1);
    chk("R9 smax imm sext", result, 64'hFFFF_FFFF_FFFF_FFFE);
    run("R9 umax imm zext", 3'd5, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFE, 1, 1);
    chk("R9 umax imm value", result, 64'hFE);
    run("R9 smin imm 32", 3'd4, 64'd4, 64'd0, 8'h80, 1, 0);
    chk("R9 smin imm 32 value", result, 64'hFFFF_FF80);
    run("R9 umin imm", 3'd6, 64'd300, 64'd1, 8'hC8, 1, 1);
    begin
      logic [63:0] first;
      first = result;
      run("R9 src_b ignored", 3'd6, 64'd300, 64'hDEAD_BEEF_0000_0000, 8'hC8, 1, 1);
      chk("R9 src_b ignored same", result, first);
    end
  endtask

  task automatic t_size;
    run("R10 cnt 64 vs 32", 3'd1, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0);
    chk("R10 upper ignored", result, 64'd0);
    run("R10 smax 64", 3'd3, 64'h0000_0000_8000_0000, 64'd1, 0, 0, 1);
    chk("R10 64 positive", result, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_misc;
    logic [63:0] held;
    run("R3 reserved", 3'd7, 64'h1234, 64'h5678, 8'h11, 0, 1);
    chk("R3 reserved zero", result, 64'h0);
    run("R1 load", 3'd1, 64'hFF, 0, 0, 0, 1);
    held = result;
    @(negedge clk);
    op = 3'd0; src_a = 64'hFFFF_FFFF_FFFF_FFFF; in_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle valid low", {63'h0, out_valid}, 64'h0);
    chk("R1 idle hold", result, held);
    chk("R11 flags idle", {63'h0, flags_we}, 64'h0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op = 3'(k); src_a = 64'h8000_0000_0000_0001; src_b = 64'h7; in_valid = 1'b1;
      #1 chk("R11 flags per op", {63'h0, flags_we}, 64'h0);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_abs();
    t_cnt();
    t_ctz();
    t_signed();
    t_unsigned();
    t_imm();
    t_size();
    t_misc();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule